// File: doc/BRIEF.md
# Signed BCD Decade Result Counter with Display Latch and Range Flags

This block holds the signed decimal result that a successive-integration converter builds up one count pulse at a time. The magnitude is kept as six BCD decades next to a separate sign bit. Each accepted pulse adds or removes one unit at a chosen decade, so a sequencer can run coarse passes at high weight and refine them at lower weight. It can also take away an offset pass by counting in the opposite direction. The analog comparator that gates the de-integrate phase sits outside: it only lets `cnt_en_i` through while its phase is active. The carry or borrow ripples through all decades in one cycle, so a pulse is accepted on every clock.

A display register keeps the sign and digits that downstream display logic shows, together with an overrange flag and an underrange flag. In run mode the register takes a new value only on a latch strobe. In hold mode the reading and the flags stay frozen. In live mode the register follows the running counter on every clock, so the count can be watched while it runs.

Top module: `decade_result_counter`

## Requirements
- R1: After reset, the counter magnitude, the sign, the displayed digits, the displayed sign and both flags are all zero. A clear (`clr_i`=1) sets the magnitude to zero and loads the sign from `pol_neg_i` (1 = negative). A clear takes priority over a count pulse in the same cycle.
- R2: With `cnt_en_i`=1 and `cnt_up_i`=1, the magnitude grows by 10^k on that clock edge, where k = `cnt_dec_i`. A decade that reaches ten wraps to zero and carries into the next decade in the same cycle.
- R3: `cnt_dec_i` picks the decade that receives the unit: 0 is the least significant digit and 5 the most significant. The digits of `disp_bcd_o` are packed so that decade k sits in bits [4k+3:4k].
- R4: With `cnt_en_i`=1 and `cnt_up_i`=0, the magnitude shrinks by 10^k. If 10^k is larger than the magnitude, the new magnitude is 10^k minus the old one and the sign inverts. This keeps the result in sign-magnitude form.
- R5: A count up that would take the magnitude past 999999 leaves it at 999999 and does not change the sign.
- R6: The overrange flag `over_o` is the registered result of magnitude > 19999. The underrange flag `under_o` is the registered result of magnitude < 1000. Both are sampled from the counter as it stood before the strobe's clock edge.
- R7: When `disp_mode_i[0]`=1 (hold, codes 01 and 11), the displayed sign, the digits and both flags do not change, whatever strobes or counts occur.
- R8: In run mode (`disp_mode_i`=00), the display register copies the counter sign and magnitude, and the flags are updated, only on a clock edge with `latch_stb_i`=1. Otherwise they stay as they were.
- R9: In live mode (`disp_mode_i`=10), the display register copies the counter on every clock edge, one cycle behind it. The flags still update only on a strobe.
- R10: A value of `cnt_dec_i` of 6 or higher makes a count pulse have no effect on the counter.
- R11: With no clear and no accepted pulse, the counter sign and magnitude keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear magnitude and load sign |
| cnt_en_i | input | 1 | Count pulse (gated by comparator) |
| cnt_up_i | input | 1 | 1 = add, 0 = subtract |
| cnt_dec_i | input | 3 | Decade weight of the pulse |
| pol_neg_i | input | 1 | Sign loaded on clear, 1 = negative |
| latch_stb_i | input | 1 | Latch strobe for the display register and flags |
| disp_mode_i | input | 2 | 00 run, 01/11 hold, 10 live |
| disp_sign_o | output | 1 | Displayed sign, 1 = negative |
| disp_bcd_o | output | 24 | Displayed BCD digits, decade k at [4k+3:4k] |
| over_o | output | 1 | Overrange flag |
| under_o | output | 1 | Underrange flag |

## Verification
A wrong internal count is hidden in run and hold modes until the next strobe. In live mode it shows at the digits one clock after the edge that produced it, so the bench keeps the display mostly in live mode and compares every cycle against a behavioural integer model. A lost decimal carry or a misplaced borrow shows as a digit error at a specific decade right after the ninth or tenth pulse. A wrong sign flip shows on `disp_sign_o` in the cycle after the zero crossing. Flag errors appear only on the cycle after a strobe, so the bench sets up the values exactly on the 999/1000 and 19999/20000 edges before strobing.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_LIVE  = 2'b10,
    MODE_HOLDX = 2'b11
  } disp_mode_e;

  function automatic logic [3:0] nines(input logic [3:0] d);
    return 4'd9 - d;
  endfunction
endpackage

// File: rtl/dcnt_bcd_step.sv
// One decade: adds or removes a single unit, reports carry / borrow out.
module dcnt_bcd_step (
  input  logic [3:0] d_i,
  input  logic       step_i,
  input  logic       up_i,
  output logic [3:0] q_o,
  output logic       carry_o
);
  always_comb begin
    q_o     = d_i;
    carry_o = 1'b0;
    if (step_i) begin
      if (up_i) begin
        if (d_i >= 4'd9) begin
          q_o     = 4'd0;
          carry_o = 1'b1;
        end else begin
          q_o = d_i + 4'd1;
        end
      end else begin
        if (d_i == 4'd0) begin
          q_o     = 4'd9;
          carry_o = 1'b1;
        end else begin
          q_o = d_i - 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/dcnt_core.sv
// Signed-magnitude BCD accumulator with single-cycle ripple.
module dcnt_core #(
  parameter int NDIG = 6,
  parameter int SELW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              up_i,
  input  logic [SELW-1:0]   sel_i,
  input  logic              pol_i,
  output logic [4*NDIG-1:0] mag_o,
  output logic              sign_o
);
  localparam int W = 4*NDIG;

  logic [W-1:0]  mag_q, raw, comp;
  logic          sign_q;
  logic [NDIG:0] rip;
  logic [NDIG:0] crip;
  logic          sel_ok, en_eff, top_out;

  assign sel_ok = (32'(sel_i) < NDIG);
  assign en_eff = en_i & sel_ok;
  assign rip[0]  = 1'b0;
  assign crip[0] = 1'b1;

  for (genvar k = 0; k < NDIG; k++) begin : g_dec
    logic hit;
    assign hit = en_eff && (sel_i == SELW'(k));
    dcnt_bcd_step u_step (
      .d_i    (mag_q[4*k +: 4]),
      .step_i (hit | rip[k]),
      .up_i   (up_i),
      .q_o    (raw[4*k +: 4]),
      .carry_o(rip[k+1])
    );
    // ten's complement of raw: nines complement plus one
    dcnt_bcd_step u_cmp (
      .d_i    (dcnt_pkg::nines(raw[4*k +: 4])),
      .step_i (crip[k]),
      .up_i   (1'b1),
      .q_o    (comp[4*k +: 4]),
      .carry_o(crip[k+1])
    );
  end

  assign top_out = rip[NDIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      sign_q <= 1'b0;
    end else if (clr_i) begin
      mag_q  <= '0;
      sign_q <= pol_i;
    end else if (en_eff) begin
      if (top_out && up_i) begin
        mag_q <= {NDIG{4'd9}};
      end else if (top_out) begin
        mag_q  <= comp;
        sign_q <= ~sign_q;
      end else begin
        mag_q <= raw;
      end
    end
  end

  assign mag_o  = mag_q;
  assign sign_o = sign_q;
endmodule

// File: rtl/dcnt_range.sv
// Magnitude compare against the overrange and underrange limits.
module dcnt_range #(
  parameter int NDIG      = 6,
  parameter int OVR_LIMIT = 19999,
  parameter int UND_LIMIT = 1000
) (
  input  logic [4*NDIG-1:0] mag_i,
  output logic              ovr_o,
  output logic              und_o
);
  logic [31:0] val;

  always_comb begin
    val = '0;
    for (int k = NDIG-1; k >= 0; k--) begin
      val = val * 32'd10 + {28'd0, mag_i[4*k +: 4]};
    end
  end

  assign ovr_o = (val > 32'(OVR_LIMIT));
  assign und_o = (val < 32'(UND_LIMIT));
endmodule

// File: rtl/dcnt_display.sv
// Display register and flag latch under the run / hold / live modes.
module dcnt_display #(
  parameter int NDIG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              stb_i,
  input  logic [4*NDIG-1:0] mag_i,
  input  logic              sign_i,
  input  logic              ovr_i,
  input  logic              und_i,
  output logic [4*NDIG-1:0] disp_o,
  output logic              sign_o,
  output logic              ovr_o,
  output logic              und_o
);
  import dcnt_pkg::*;

  disp_mode_e mode;
  logic       take_val, take_flag;

  assign mode      = disp_mode_e'(mode_i);
  assign take_val  = ((mode == MODE_RUN) && stb_i) || (mode == MODE_LIVE);
  assign take_flag = stb_i && ((mode == MODE_RUN) || (mode == MODE_LIVE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_o <= '0;
      sign_o <= 1'b0;
      ovr_o  <= 1'b0;
      und_o  <= 1'b0;
    end else begin
      if (take_val) begin
        disp_o <= mag_i;
        sign_o <= sign_i;
      end
      if (take_flag) begin
        ovr_o <= ovr_i;
        und_o <= und_i;
      end
    end
  end
endmodule

// File: rtl/decade_result_counter.sv
module decade_result_counter #(
  parameter int NDIG      = 6,
  parameter int SELW      = 3,
  parameter int OVR_LIMIT = 19999,
  parameter int UND_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cnt_en_i,
  input  logic              cnt_up_i,
  input  logic [SELW-1:0]   cnt_dec_i,
  input  logic              pol_neg_i,
  input  logic              latch_stb_i,
  input  logic [1:0]        disp_mode_i,
  output logic              disp_sign_o,
  output logic [4*NDIG-1:0] disp_bcd_o,
  output logic              over_o,
  output logic              under_o
);
  logic [4*NDIG-1:0] mag_q;
  logic              sign_q;
  logic              ovr_now, und_now;

  dcnt_core #(.NDIG(NDIG), .SELW(SELW)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_i),
    .en_i  (cnt_en_i),
    .up_i  (cnt_up_i),
    .sel_i (cnt_dec_i),
    .pol_i (pol_neg_i),
    .mag_o (mag_q),
    .sign_o(sign_q)
  );

  dcnt_range #(.NDIG(NDIG), .OVR_LIMIT(OVR_LIMIT), .UND_LIMIT(UND_LIMIT)) u_range (
    .mag_i(mag_q),
    .ovr_o(ovr_now),
    .und_o(und_now)
  );

  dcnt_display #(.NDIG(NDIG)) u_disp (
    .clk   (clk),
    .rst_n (rst_n),
    .mode_i(disp_mode_i),
    .stb_i (latch_stb_i),
    .mag_i (mag_q),
    .sign_i(sign_q),
    .ovr_i (ovr_now),
    .und_i (und_now),
    .disp_o(disp_bcd_o),
    .sign_o(disp_sign_o),
    .ovr_o (over_o),
    .und_o (under_o)
  );
endmodule

// File: rtl/decade_result_counter_chk.sv
module decade_result_counter_chk #(
  parameter int NDIG = 6,
  parameter int SELW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              cnt_en_i,
  input logic              cnt_up_i,
  input logic [SELW-1:0]   cnt_dec_i,
  input logic              pol_neg_i,
  input logic              latch_stb_i,
  input logic [1:0]        disp_mode_i,
  input logic              disp_sign_o,
  input logic [4*NDIG-1:0] disp_bcd_o,
  input logic              over_o,
  input logic              under_o,
  input logic [4*NDIG-1:0] mag_q,
  input logic              sign_q
);
  logic dec_ok;
  assign dec_ok = (32'(cnt_dec_i) < NDIG);

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mag_q == '0) && (sign_q == $past(pol_neg_i)));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !cnt_en_i) |=> $stable(mag_q) && $stable(sign_q));

  a_r10_bad_decade: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !dec_ok) |=> $stable(mag_q) && $stable(sign_q));

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_en_i && cnt_up_i && dec_ok && mag_q == {NDIG{4'd9}})
    |=> (mag_q == {NDIG{4'd9}}) && $stable(sign_q));

  a_r4_zero_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_en_i && !cnt_up_i && dec_ok && mag_q == '0)
    |=> (sign_q != $past(sign_q)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    disp_mode_i[0] |=> $stable(disp_bcd_o) && $stable(disp_sign_o)
                      && $stable(over_o) && $stable(under_o));

  a_r8_run_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_mode_i == 2'b00 && !latch_stb_i) |=> $stable(disp_bcd_o) && $stable(disp_sign_o));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_o && under_o));

  for (genvar k = 0; k < NDIG; k++) begin : g_bcd
    a_r3_digit_bcd: assert property (@(posedge clk) disable iff (!rst_n)
      disp_bcd_o[4*k +: 4] <= 4'd9);
  end
endmodule

bind decade_result_counter decade_result_counter_chk #(.NDIG(NDIG), .SELW(SELW)) u_chk (.*);

// File: tb/sim_decade_result_counter.sv
module sim_decade_result_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 6;
  localparam int SELW = 3;
  localparam int MAXMAG = 999999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0, cnt_en_i = 1'b0, cnt_up_i = 1'b0, pol_neg_i = 1'b0, latch_stb_i = 1'b0;
  logic [SELW-1:0] cnt_dec_i = '0;
  logic [1:0] disp_mode_i = 2'b10;
  logic disp_sign_o, over_o, under_o;
  logic [4*NDIG-1:0] disp_bcd_o;

  decade_result_counter u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference
  int m_mag = 0, d_mag = 0;
  bit m_sign = 0, d_sign = 0, d_ovr = 0, d_und = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mag = 0; m_sign = 0; d_mag = 0; d_sign = 0; d_ovr = 0; d_und = 0;
    end else begin
      int old_mag, w;
      bit old_sign;
      old_mag = m_mag; old_sign = m_sign;
      if ((disp_mode_i == 2'b00 && latch_stb_i) || disp_mode_i == 2'b10) begin
        d_mag = old_mag; d_sign = old_sign;
      end
      if (latch_stb_i && !disp_mode_i[0]) begin
        d_ovr = (old_mag > 19999); d_und = (old_mag < 1000);
      end
      if (clr_i) begin
        m_mag = 0; m_sign = pol_neg_i;
      end else if (cnt_en_i && int'(cnt_dec_i) < NDIG) begin
        w = 10 ** int'(cnt_dec_i);
        if (cnt_up_i) m_mag = (old_mag + w > MAXMAG) ? MAXMAG : old_mag + w;
        else if (old_mag >= w) m_mag = old_mag - w;
        else begin m_mag = w - old_mag; m_sign = ~old_sign; end
      end
    end
  end

  function automatic int bcd2int(logic [4*NDIG-1:0] b);
    int v = 0;
    for (int k = NDIG-1; k >= 0; k--) v = v*10 + int'(b[4*k +: 4]);
    return v;
  endfunction

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("digits", bcd2int(disp_bcd_o), d_mag);
    check("sign", int'(disp_sign_o), int'(d_sign));
    check("over", int'(over_o), int'(d_ovr));
    check("under", int'(under_o), int'(d_und));
  endtask

  // one cycle: compare then drive
  task automatic cyc(bit en, bit up, int dec, bit clr, bit pol, bit stb, logic [1:0] mode);
    @(negedge clk);
    compare_all();
    cnt_en_i = en; cnt_up_i = up; cnt_dec_i = SELW'(dec); clr_i = clr;
    pol_neg_i = pol; latch_stb_i = stb; disp_mode_i = mode;
  endtask

  task automatic pulses(int dec, int n, bit up, logic [1:0] mode);
    for (int i = 0; i < n; i++) cyc(1, up, dec, 0, 0, 0, mode);
  endtask

  task automatic idle(int n, logic [1:0] mode);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, mode);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    // R1: reset state and clear
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset digits R1", bcd2int(disp_bcd_o), 0);
    check("reset flags R1", int'(over_o) + int'(under_o), 0);
    rst_n = 1'b1;
    idle(3, 2'b10);
    cyc(0, 0, 0, 1, 1, 0, 2'b10);
    idle(2, 2'b10);
    cyc(1, 1, 2, 1, 0, 0, 2'b10);   // clear beats count
    idle(2, 2'b10);

    tag = "R2";  // carries through decade 0
    pulses(0, 25, 1, 2'b10);
    pulses(1, 12, 1, 2'b10);
    idle(2, 2'b10);

    tag = "R3";  // decade selection and bit packing
    cyc(0, 0, 0, 1, 0, 0, 2'b10);
    pulses(3, 3, 1, 2'b10);
    pulses(5, 1, 1, 2'b10);
    pulses(1, 4, 1, 2'b10);
    idle(2, 2'b10);

    tag = "R4";  // borrow and sign flip
    cyc(0, 0, 0, 1, 0, 0, 2'b10);
    pulses(0, 3, 1, 2'b10);
    pulses(2, 1, 0, 2'b10);        // 3 - 100 -> -97
    pulses(0, 5, 0, 2'b10);
    pulses(1, 10, 0, 2'b10);       // crosses zero again
    pulses(4, 1, 0, 2'b10);
    idle(2, 2'b10);

    tag = "R5";  // saturation
    cyc(0, 0, 0, 1, 1, 0, 2'b10);
    pulses(5, 11, 1, 2'b10);
    pulses(0, 3, 1, 2'b10);
    idle(2, 2'b10);

    tag = "R6";  // flag boundaries
    cyc(0, 0, 0, 1, 0, 0, 2'b00);
    pulses(4, 1, 1, 2'b00); pulses(3, 9, 1, 2'b00); pulses(2, 9, 1, 2'b00);
    pulses(1, 9, 1, 2'b00); pulses(0, 9, 1, 2'b00);       // 19999
    cyc(0, 0, 0, 0, 0, 1, 2'b00); idle(2, 2'b00);
    pulses(0, 1, 1, 2'b00);                               // 20000
    cyc(0, 0, 0, 0, 0, 1, 2'b00); idle(2, 2'b00);
    cyc(0, 0, 0, 1, 0, 0, 2'b00);
    pulses(2, 9, 1, 2'b00); pulses(1, 9, 1, 2'b00); pulses(0, 9, 1, 2'b00); // 999
    cyc(0, 0, 0, 0, 0, 1, 2'b00); idle(2, 2'b00);
    pulses(0, 1, 1, 2'b00);                               // 1000
    cyc(0, 0, 0, 0, 0, 1, 2'b00); idle(2, 2'b00);

    tag = "R7";  // hold freezes display and flags
    pulses(4, 3, 1, 2'b01);
    cyc(0, 0, 0, 0, 0, 1, 2'b01);
    cyc(1, 1, 5, 0, 0, 1, 2'b11);
    idle(3, 2'b11);

    tag = "R8";  // run mode only on strobe
    pulses(2, 4, 1, 2'b00);
    idle(2, 2'b00);
    cyc(0, 0, 0, 0, 0, 1, 2'b00);
    pulses(1, 2, 0, 2'b00);
    idle(2, 2'b00);

    tag = "R9";  // live follows, flags on strobe
    pulses(3, 4, 1, 2'b10);
    cyc(1, 1, 0, 0, 0, 1, 2'b10);
    idle(2, 2'b10);

    tag = "R10";  // out-of-range decade ignored
    cyc(1, 1, 6, 0, 0, 0, 2'b10);
    cyc(1, 0, 7, 0, 0, 0, 2'b10);
    idle(2, 2'b10);

    tag = "R11";  // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      cyc(r < 60, $urandom_range(0, 1) == 1, int'($urandom_range(0, 7)),
          r > 96, $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
          ($urandom_range(0, 9) < 7) ? 2'b10 : 2'($urandom_range(0, 3)));
    end
    idle(3, 2'b10);
    @(negedge clk);
    compare_all();
    finish_run();
  end
endmodule